// File: doc/BRIEF.md
# Multi-channel decrementing timer unit

A register-mapped peripheral holding four independent down-counters that share one interrupt section. Each channel has its own load value, live count, control word and deferred reload value. A channel can wrap freely through its full range, reload itself periodically from the deferred value, or count down once and stop. Counting advances only on cycles where the timer clock enable input is high. Each step is further divided by a per-channel prescaler.

Software drives the block over a simple synchronous word bus. Writes take effect at the clock edge where the write enable is high. Reads are combinational from the address. Each channel runs a three-state machine:
- `CH_IDLE`: the channel is disabled and the count is held.
- `CH_RUN`: the channel is counting.
- `CH_DONE`: a one-shot channel has expired.

The transitions are:
- enable-set: `CH_IDLE` to `CH_RUN`, when a control write sets the enable bit.
- disable: `CH_RUN` or `CH_DONE` to `CH_IDLE`, when the enable bit is cleared.
- expire: `CH_RUN` to `CH_DONE`, on a one-shot underflow.
- rearm: `CH_DONE` to `CH_RUN`, on a load write while enabled.

A load write while in `CH_RUN` keeps the channel in `CH_RUN` and restarts it.

Every underflow sets the channel's raw interrupt bit. The raw bits are gated by a mask and ORed into one interrupt output.

Top module: `dtimer_top`

## Requirements
- R1: After reset, every readable register reads 0, every channel is in `CH_IDLE`, and `irq` is low.
- R2: Shared words sit at these byte addresses:
  - 0x00: mask, read/write.
  - 0x04: raw status, read-only.
  - 0x08: masked status, read-only.
  - 0x0C: clear, write-only, reads 0.
  
  Bit n of each shared word belongs to channel n. Channel n occupies 0x10+0x10·n:
  - +0x0: load, reads back the last value written.
  - +0x4: current count, read-only.
  - +0x8: control.
  - +0xC: deferred reload.
  
  The control bits are:
  - bit 7: enable.
  - bit 6: periodic.
  - bits 3:2: prescaler.
  - bit 1: 32-bit width.
  - bit 0: one-shot.
  
  Other control bits read 0.
- R3: A load write sets the count at that same edge, masked to the width currently selected. It also copies the value into the deferred reload register and restarts the prescaler.
- R4: A running channel takes one step per prescaled tick. A step decrements a non-zero count. A step taken on a count of zero is an underflow. With a divide-by-1 prescaler and `tick_en` high, a channel enabled with count N underflows on the (N+1)th edge after the enabling edge.
- R5: In free-running mode (bits 6 and 0 clear), an underflow wraps the count to all ones of the selected width.
- R6: In periodic mode (bit 6 set, bit 0 clear), an underflow reloads the count from the deferred reload value, masked to the width.
- R7: Writing the deferred reload register leaves the current count unchanged.
- R8: In one-shot mode (bit 0 set, taking priority over bit 6), an underflow leaves the count at 0 and moves to `CH_DONE`. No further underflow happens until a load write rearms the channel.
- R9: Prescaler code 00 divides by 1, 01 by 16, and 10 or 11 by 256. Only cycles with `tick_en` high advance the prescaler. While `tick_en` is low, the count is frozen.
- R10: With bit 1 clear, only the low 16 bits count. The upper 16 bits read 0 after a load or a step, and the count wraps to 0xFFFF.
- R11: An underflow sets the channel's raw bit. Writing 1 to bit n of the clear word clears raw bit n. If an underflow and a clear land in the same cycle, the bit stays set.
- R12: Masked status equals raw AND mask, and `irq` is the OR of the masked bits. A mask of 0 keeps `irq` low.
- R13: After the enable bit is cleared, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable; prescalers advance only when high |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume the following about the inputs:
- The bus carries at most one write per cycle.
- Reads have no side effects.
- The low two address bits are zero.

The checks on reload and width hold for any control change, including one in the same cycle as an underflow. The stimulus changes bus signals and `tick_en` only at falling edges and writes whole words at aligned addresses. It always loads a channel while the channel is disabled before enabling it, except in the deliberate load-while-running and clear-versus-underflow cases. This keeps the bench's arithmetic model of count, reload and raw status aligned with the design edge for edge.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

    // control word bit positions
    localparam int CTL_EN    = 7;
    localparam int CTL_PER   = 6;
    localparam int CTL_PS_HI = 3;
    localparam int CTL_PS_LO = 2;
    localparam int CTL_WIDE  = 1;
    localparam int CTL_ONE   = 0;
    localparam logic [7:0] CTL_KEEP = 8'hCF;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        REG_LOAD   = 2'd0,
        REG_VALUE  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_BGLOAD = 2'd3
    } ch_reg_e;

    typedef enum logic [1:0] {
        SH_MASK   = 2'd0,
        SH_RAW    = 2'd1,
        SH_MASKED = 2'd2,
        SH_CLEAR  = 2'd3
    } sh_reg_e;

endpackage

// File: rtl/dtimer_chan.sv
module dtimer_chan
    import dtimer_pkg::*;
#(
    parameter int DW         = 32,
    parameter int NARROW_W   = 16,
    parameter int PS_MID_LOG = 4,
    parameter int PS_MAX_LOG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          ld_we,
    input  logic          ctl_we,
    input  logic          bg_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] load_q,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] bg_q,
    output logic [7:0]    ctl_q,
    output logic          uf
);
    localparam int PRE_W = PS_MAX_LOG;
    localparam logic [PRE_W-1:0] LAST_MID = PRE_W'((1 << PS_MID_LOG) - 1);
    localparam logic [PRE_W-1:0] LAST_MAX = {PRE_W{1'b1}};
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    ch_state_e        st_q, st_nx;
    logic [7:0]       ctl_r;
    logic [DW-1:0]    load_r, bg_r, cnt_r, cnt_nx, wmask;
    logic [PRE_W-1:0] pre_r, pre_nx, div_last;
    logic             en_nx, step, cnt_zero;

    assign load_q = load_r;
    assign cnt_q  = cnt_r;
    assign bg_q   = bg_r;
    assign ctl_q  = ctl_r;

    // software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r  <= '0;
            load_r <= '0;
            bg_r   <= '0;
        end else begin
            if (ctl_we)         ctl_r  <= wdata[7:0] & CTL_KEEP;
            if (ld_we)          load_r <= wdata;
            if (ld_we || bg_we) bg_r   <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_nx;
    end

    // next-state logic
    always_comb begin
        en_nx = ctl_we ? wdata[CTL_EN] : ctl_r[CTL_EN];
        st_nx = st_q;
        unique case (st_q)
            CH_IDLE: if (en_nx) st_nx = CH_RUN;
            CH_RUN: begin
                if (!en_nx)                       st_nx = CH_IDLE;
                else if (uf && ctl_r[CTL_ONE])    st_nx = CH_DONE;
            end
            CH_DONE: begin
                if (!en_nx)     st_nx = CH_IDLE;
                else if (ld_we) st_nx = CH_RUN;
            end
            default: st_nx = CH_IDLE;
        endcase
    end

    // datapath outputs: prescaler, step, count
    always_comb begin
        wmask = ctl_r[CTL_WIDE] ? {DW{1'b1}} : NARROW_MASK;
        unique case (ctl_r[CTL_PS_HI:CTL_PS_LO])
            2'b00:   div_last = '0;
            2'b01:   div_last = LAST_MID;
            default: div_last = LAST_MAX;
        endcase
        step     = (st_q == CH_RUN) && tick_en && (pre_r >= div_last);
        cnt_zero = ((cnt_r & wmask) == '0);
        uf       = step && cnt_zero && !ld_we;

        if (ld_we || st_q != CH_RUN) pre_nx = '0;
        else if (tick_en)            pre_nx = step ? '0 : pre_r + 1'b1;
        else                         pre_nx = pre_r;

        cnt_nx = cnt_r;
        if (ld_we) begin
            cnt_nx = wdata & wmask;
        end else if (step) begin
            if (!cnt_zero)             cnt_nx = (cnt_r - 1'b1) & wmask;
            else if (ctl_r[CTL_ONE])   cnt_nx = '0;
            else if (ctl_r[CTL_PER])   cnt_nx = bg_r & wmask;
            else                       cnt_nx = wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
            pre_r <= '0;
        end else begin
            cnt_r <= cnt_nx;
            pre_r <= pre_nx;
        end
    end

    assert_narrow_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_we && !ctl_r[CTL_WIDE]) |=> (cnt_r[DW-1:NARROW_W] == '0));

    assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && ctl_r[CTL_PER] && !ctl_r[CTL_ONE]) |=> (cnt_r == ($past(bg_r) & $past(wmask))));

    assert_done_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_DONE) |-> (cnt_r == '0));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !ld_we) |=> $stable(cnt_r));

endmodule

// File: rtl/dtimer_irq.sv
module dtimer_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wbits,
    input  logic [NCH-1:0] uf,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] raw_q,
    output logic [NCH-1:0] masked_q,
    output logic           irq
);
    logic [NCH-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wbits;
            // a fresh underflow outranks a clear in the same cycle
            raw_q <= (raw_q & ~clr_bits) | uf;
        end
    end

    assign masked_q = raw_q & mask_q;
    assign irq      = |masked_q;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|uf) |=> ((raw_q & $past(uf)) == $past(uf)));

    assert_mask_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
    import dtimer_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DW         = 32,
    parameter int ADDR_W     = 8,
    parameter int NARROW_W   = 16,
    parameter int PS_MID_LOG = 4,
    parameter int PS_MAX_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic [1:0]       word;
    logic [1:0]       unused_low;
    logic             sh_hit;

    logic [DW-1:0]  ch_load [NCH];
    logic [DW-1:0]  ch_cnt  [NCH];
    logic [DW-1:0]  ch_bg   [NCH];
    logic [7:0]     ch_ctl  [NCH];
    logic [NCH-1:0] uf_v, mask_v, raw_v, masked_v;

    assign blk        = bus_addr[ADDR_W-1:4];
    assign word       = bus_addr[3:2];
    assign unused_low = bus_addr[1:0];
    assign sh_hit     = (blk == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic hit;
        assign hit = bus_we && (blk == BLK_W'(i + 1));

        dtimer_chan #(
            .DW(DW), .NARROW_W(NARROW_W),
            .PS_MID_LOG(PS_MID_LOG), .PS_MAX_LOG(PS_MAX_LOG)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .ld_we  (hit && word == REG_LOAD),
            .ctl_we (hit && word == REG_CTRL),
            .bg_we  (hit && word == REG_BGLOAD),
            .wdata  (bus_wdata),
            .load_q (ch_load[i]),
            .cnt_q  (ch_cnt[i]),
            .bg_q   (ch_bg[i]),
            .ctl_q  (ch_ctl[i]),
            .uf     (uf_v[i])
        );
    end

    dtimer_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_we && sh_hit && word == SH_MASK),
        .clr_we  (bus_we && sh_hit && word == SH_CLEAR),
        .wbits   (bus_wdata[NCH-1:0]),
        .uf      (uf_v),
        .mask_q  (mask_v),
        .raw_q   (raw_v),
        .masked_q(masked_v),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sh_hit) begin
            unique case (word)
                SH_MASK:   bus_rdata = {{(DW-NCH){1'b0}}, mask_v};
                SH_RAW:    bus_rdata = {{(DW-NCH){1'b0}}, raw_v};
                SH_MASKED: bus_rdata = {{(DW-NCH){1'b0}}, masked_v};
                default:   bus_rdata = '0;
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (blk == BLK_W'(i + 1)) begin
                unique case (word)
                    REG_LOAD:  bus_rdata = ch_load[i];
                    REG_VALUE: bus_rdata = ch_cnt[i];
                    REG_CTRL:  bus_rdata = {{(DW-8){1'b0}}, ch_ctl[i]};
                    default:   bus_rdata = ch_bg[i];
                endcase
            end
        end
    end

endmodule

// File: tb/dtimer_top_bench.sv
`timescale 1ns/1ps
module dtimer_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam int A_MASK = 0, A_RAW = 4, A_MSKD = 8, A_CLR = 12;

    always #2.5 clk = ~clk;

    dtimer_top u_dtimer_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int ca(input int ch, input int r);
        return 16 + 16 * ch + 4 * r;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #0.4;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // arithmetic model of one step: mode 0 free, 1 periodic, 2 one-shot
    task automatic mstep(inout logic [31:0] c, input int mode, input logic [31:0] b,
                         inout bit run, inout bit ufs);
        if (run) begin
            if (c == 0) begin
                ufs = 1;
                if (mode == 2)      run = 0;
                else if (mode == 1) c = b;
                else                c = 32'hFFFF_FFFF;
            end else begin
                c = c - 1;
            end
        end
    endtask

    task automatic idle_all();
        for (int c = 0; c < 4; c++) wr(ca(c, 2), 32'h0);
        wr(A_CLR, 32'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 80; a += 4) begin
            @(negedge clk);
            rd(a, v);
            chk("R1 reset read", v, 32'h0);
        end
        chk("R1 irq low", {31'h0, irq}, 32'h0);

        // R2: register map and readback
        wr(ca(2, 0), 32'h0000_1234);
        rd(ca(2, 0), v); chk("R2 load readback", v, 32'h0000_1234);
        wr(ca(2, 2), 32'hFF);
        rd(ca(2, 2), v); chk("R2 control bits", v, 32'hCF);
        wr(ca(2, 2), 32'h0);
        wr(A_MASK, 32'h5);
        rd(A_MASK, v); chk("R2 mask readback", v, 32'h5);
        rd(A_CLR, v);  chk("R2 clear reads zero", v, 32'h0);
        wr(A_MASK, 32'h0);
        idle_all();

        // R4 R5 R6 R7 R8: sweep channels, modes and start counts
        for (int ch = 0; ch < 4; ch++) begin
            for (int mode = 0; mode < 3; mode++) begin
                for (int n = 0; n < 4; n++) begin
                    logic [31:0] mc;
                    bit run, ufs;
                    logic [31:0] ctlv;
                    if (n == 2) continue;
                    wr(ca(ch, 2), 32'h0);
                    wr(ca(ch, 0), 32'(n));
                    wr(ca(ch, 3), 32'h2);
                    rd(ca(ch, 1), v);
                    chk("R7 bgload write keeps count", v, 32'(n));
                    wr(A_CLR, 32'hF);
                    ctlv = 32'h82 | (mode == 1 ? 32'h40 : 32'h0) | (mode == 2 ? 32'h1 : 32'h0);
                    wr(ca(ch, 2), ctlv);
                    mc = 32'(n); run = 1; ufs = 0;
                    for (int j = 1; j <= 10; j++) begin
                        @(negedge clk);
                        mstep(mc, mode, 32'h2, run, ufs);
                        rd(ca(ch, 1), v);
                        case (mode)
                            0: chk("R5 free-run count", v, mc);
                            1: chk("R6 periodic count", v, mc);
                            default: chk("R8 one-shot count", v, mc);
                        endcase
                    end
                    rd(A_RAW, v);
                    chk("R4 underflow raw bit", v, ufs ? (32'h1 << ch) : 32'h0);
                    wr(ca(ch, 2), 32'h0);
                end
            end
        end
        idle_all();

        // R10: 16-bit width
        wr(ca(0, 0), 32'h1234_0001);
        rd(ca(0, 1), v); chk("R10 narrow load", v, 32'h0000_0001);
        wr(ca(0, 2), 32'h80);
        @(negedge clk); rd(ca(0, 1), v); chk("R10 narrow step", v, 32'h0);
        @(negedge clk); rd(ca(0, 1), v); chk("R10 narrow wrap", v, 32'h0000_FFFF);
        @(negedge clk); rd(ca(0, 1), v); chk("R10 narrow after wrap", v, 32'h0000_FFFE);
        wr(ca(0, 2), 32'h0);
        wr(ca(0, 0), 32'h1);
        wr(ca(0, 3), 32'hABCD_0003);
        wr(ca(0, 2), 32'hC0);
        @(negedge clk); rd(ca(0, 1), v); chk("R10 narrow periodic step", v, 32'h0);
        @(negedge clk); rd(ca(0, 1), v); chk("R10 narrow reload masked", v, 32'h3);
        idle_all();

        // R9: prescaler and tick enable
        wr(ca(1, 2), 32'h02);
        wr(ca(1, 0), 32'h1);
        wr(ca(1, 2), 32'h86);
        repeat (15) @(negedge clk);
        rd(ca(1, 1), v); chk("R9 div16 before tick", v, 32'h1);
        @(negedge clk);
        rd(ca(1, 1), v); chk("R9 div16 at tick", v, 32'h0);
        tick_en = 1'b0;
        repeat (40) @(negedge clk);
        rd(ca(1, 1), v); chk("R9 tick_en low freezes", v, 32'h0);
        tick_en = 1'b1;
        for (int code = 2; code < 4; code++) begin
            wr(ca(1, 2), 32'h02);
            wr(ca(1, 0), 32'h5);
            wr(ca(1, 2), 32'h82 | 32'(code << 2));
            repeat (255) @(negedge clk);
            rd(ca(1, 1), v); chk("R9 div256 before tick", v, 32'h5);
            @(negedge clk);
            rd(ca(1, 1), v); chk("R9 div256 at tick", v, 32'h4);
        end

        // R3: load while running restarts count and prescaler
        wr(ca(1, 2), 32'h02);
        wr(ca(1, 0), 32'd100);
        wr(ca(1, 2), 32'h86);
        repeat (10) @(negedge clk);
        wr(ca(1, 0), 32'h2);
        rd(ca(1, 1), v); chk("R3 immediate load", v, 32'h2);
        rd(ca(1, 3), v); chk("R3 load copies bgload", v, 32'h2);
        repeat (15) @(negedge clk);
        rd(ca(1, 1), v); chk("R3 prescaler restarted", v, 32'h2);
        @(negedge clk);
        rd(ca(1, 1), v); chk("R3 first step after restart", v, 32'h1);

        // R13: disable holds count
        wr(ca(1, 2), 32'h82);
        repeat (3) @(negedge clk);
        wr(ca(1, 2), 32'h02);
        rd(ca(1, 1), v);
        repeat (5) @(negedge clk);
        rd(ca(1, 1), v2); chk("R13 count held when disabled", v2, v);
        idle_all();
        wr(A_MASK, 32'h0);

        // R11 R12 R8: interrupt path and one-shot
        wr(ca(3, 0), 32'h0);
        wr(ca(3, 2), 32'h83);
        @(negedge clk);
        rd(A_RAW, v);  chk("R11 raw set on underflow", v, 32'h8);
        rd(A_MSKD, v); chk("R12 masked with mask 0", v, 32'h0);
        chk("R12 irq low with mask 0", {31'h0, irq}, 32'h0);
        wr(A_MASK, 32'h8);
        rd(A_MSKD, v); chk("R12 masked status", v, 32'h8);
        chk("R12 irq high", {31'h0, irq}, 32'h1);
        wr(A_CLR, 32'h8);
        rd(A_RAW, v); chk("R11 clear", v, 32'h0);
        chk("R12 irq low after clear", {31'h0, irq}, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_RAW, v);     chk("R8 one-shot fires once", v, 32'h0);
        rd(ca(3, 1), v);  chk("R8 one-shot stays at zero", v, 32'h0);
        wr(ca(3, 0), 32'h2);
        repeat (2) @(negedge clk);
        rd(A_RAW, v); chk("R8 rearm before underflow", v, 32'h0);
        @(negedge clk);
        rd(A_RAW, v); chk("R8 rearm underflow", v, 32'h8);
        idle_all();

        // R11: set wins over clear
        wr(ca(0, 0), 32'h0);
        wr(ca(0, 3), 32'h0);
        wr(ca(0, 2), 32'hC2);
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); chk("R11 set wins over clear", v, 32'h1);
        wr(A_MASK, 32'hF);
        chk("R12 irq with full mask", {31'h0, irq}, 32'h1);
        wr(A_MASK, 32'h0);
        chk("R12 mask 0 silences irq", {31'h0, irq}, 32'h0);
        wr(ca(0, 2), 32'h0);
        wr(A_CLR, 32'h1);
        rd(A_RAW, v); chk("R11 clear when idle", v, 32'h0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule